// File: doc/BRIEF.md
# Periodic Interrupt Reinjection Tracker

This block sits between a periodic timer and an interrupt line. Each timer tick adds one to a backlog of undelivered interrupts. The block sends one interrupt pulse at a time and will not send the next one until the consumer acknowledges the last. A slow consumer therefore still sees every tick, up to the depth of the backlog counter.

Each acknowledge removes one entry from the backlog. The backlog is emptied, and the handshake returns to its ready state, when the timer is reprogrammed or when the interrupt line is unmasked. A delivery enable input can hold delivery off. Ticks keep being counted while delivery is held off.

Each delivery is an edge pulse. The line is driven high for a set number of cycles and then low for at least one cycle. The top-level output `pending_o` reports whether any backlog remains.

Top module: `reinj_tracker`

## Requirements
- R1: After synchronous active-low reset, `irq_o` and `pending_o` are 0 and the handshake is ready. The first tick after reset can therefore be delivered without an acknowledge.
- R2: A tick with no acknowledge and no clear in the same cycle adds one to the backlog. `pending_o` goes to 1 on the clock edge that samples the tick.
- R3: A delivery starts when all of these hold in one cycle: the backlog is nonzero, the handshake is ready, delivery is enabled, no pulse is in progress, and there is no clear. `irq_o` rises on the next edge and the handshake leaves the ready state. No further delivery starts until an acknowledge arrives.
- R4: An acknowledge removes one from the backlog, never going below zero, and returns the handshake to ready. An acknowledge at an empty backlog leaves `pending_o` at 0.
- R5: A reprogram strobe (`reload_i`) empties the backlog and sets the handshake ready. It takes priority over a tick or acknowledge in the same cycle, and no delivery starts in that cycle.
- R6: An unmask strobe (`unmask_i`) has exactly the same effect as R5.
- R7: Each delivery holds `irq_o` high for PULSE_HIGH cycles (default 2). It is followed by at least one low cycle before another rise.
- R8: The backlog saturates at 2^CNT_W-1 (15 by default). Further ticks are dropped, and the number of deliveries needed to drain a saturated backlog is exactly that maximum.
- R9: A tick and an acknowledge in the same cycle cancel when the backlog is nonzero, leaving it unchanged. When the backlog is zero the result is one.
- R10: While `inject_en_i` is 0 no delivery starts, but ticks are still counted. Delivery resumes when it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe: timer period expired |
| ack_i | input | 1 | One-cycle strobe: consumer acknowledged an interrupt |
| reload_i | input | 1 | One-cycle strobe: timer count reprogrammed |
| unmask_i | input | 1 | One-cycle strobe: interrupt line unmasked |
| inject_en_i | input | 1 | Level: delivery allowed |
| irq_o | output | 1 | Interrupt pulse output |
| pending_o | output | 1 | Backlog is nonzero |

## Verification
The assertions assume that every input is a synchronous, single-bit level that is valid at each clock edge. They also assume that strobes may coincide in any combination, including an acknowledge that matches no pulse. The random stimulus stays within these assumptions. It drives every input at the falling edge from a fixed-seed generator and lets ticks, acknowledges, clears and enable changes overlap freely, including acknowledges at an empty backlog. Directed runs add saturation, cancelling tick/acknowledge pairs and clears that arrive in the same cycle as other strobes.

// File: rtl/reinj_pkg.sv
// Package: shared types for the reinjection tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package reinj_pkg;

    // Phase of the output pulse shaper
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_GAP  = 2'd2
    } pulse_ph_e;

endpackage

// File: rtl/reinj_backlog.sv
// Module: saturating backlog counter of undelivered ticks.
// Counts up on a tick and down on a decrement request, with a floor of zero
// and a ceiling of 2^CNT_W-1. A clear strobe overrides both.
// Assumes: all inputs are synchronous single-cycle strobes.
module reinj_backlog #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic dec_i,
    input  logic clear_i,
    output logic nonzero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             do_dec;
    logic             at_max;

    assign do_dec    = dec_i && (cnt_q != '0);
    assign at_max    = (cnt_q == CNT_MAX);
    assign nonzero_o = (cnt_q != '0);

    // Next backlog value: clear first, then net tick against decrement
    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && !do_dec) begin
            cnt_d = at_max ? CNT_MAX : cnt_q + CNT_ONE;
        end else if (do_dec && !tick_i) begin
            cnt_d = cnt_q - CNT_ONE;
        end
    end

    // Backlog register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && tick_i && !dec_i && !clear_i) |=> (cnt_q == CNT_MAX));
    p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
    p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '0) && dec_i && !tick_i && !clear_i) |=> (cnt_q == '0));
    p_tie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q != '0) && tick_i && dec_i && !clear_i) |=> $stable(cnt_q));
    p_tick_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !dec_i && !clear_i) |=> (cnt_q != '0));

endmodule

// File: rtl/reinj_handshake.sv
// Module: acknowledge handshake flag.
// Ready after reset or a clear. It drops when a delivery is issued and
// returns on an acknowledge.
// Assumes: fire_i is only raised while acked_o is 1.
module reinj_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic fire_i,
    input  logic ack_i,
    output logic acked_o
);
    // Ready flag: clear beats issue, issue beats acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       acked_o <= 1'b1;
        else if (clear_i) acked_o <= 1'b1;
        else if (fire_i)  acked_o <= 1'b0;
        else if (ack_i)   acked_o <= 1'b1;
    end

    p_fire_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !clear_i) |=> !acked_o);
    p_ack_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !fire_i) |=> acked_o);
    p_clear_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> acked_o);

endmodule

// File: rtl/reinj_pulse.sv
// Module: output pulse shaper.
// On a fire strobe it drives the line high for PULSE_HIGH cycles, then low
// for one gap cycle, then reports idle again.
// Assumes: fire_i is raised only while idle_o is 1.
module reinj_pulse
    import reinj_pkg::*;
#(
    parameter int PULSE_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic idle_o,
    output logic irq_o
);
    localparam int HW = (PULSE_HIGH > 1) ? $clog2(PULSE_HIGH) : 1;

    pulse_ph_e ph_q;
    logic      hi_done;

    generate
        if (PULSE_HIGH == 1) begin : g_single
            assign hi_done = 1'b1;
        end else begin : g_counted
            logic [HW-1:0] hi_cnt_q;
            // Cycles left in the high phase
            always_ff @(posedge clk) begin
                if (!rst_n)                  hi_cnt_q <= '0;
                else if (fire_i)             hi_cnt_q <= HW'(PULSE_HIGH - 1);
                else if (ph_q == PH_HIGH && hi_cnt_q != '0)
                                             hi_cnt_q <= hi_cnt_q - HW'(1);
            end
            assign hi_done = (hi_cnt_q == '0);
        end
    endgenerate

    // Phase sequencing: idle -> high -> gap -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (fire_i)  ph_q <= PH_HIGH;
                PH_HIGH: if (hi_done) ph_q <= PH_GAP;
                PH_GAP:               ph_q <= PH_IDLE;
                default:              ph_q <= PH_IDLE;
            endcase
        end
    end

    assign idle_o = (ph_q == PH_IDLE);
    assign irq_o  = (ph_q == PH_HIGH);

    p_gap_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |=> !irq_o);
    p_rise_from_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(fire_i));

endmodule

// File: rtl/reinj_tracker.sv
// Module: periodic interrupt reinjection tracker (top).
// Counts undelivered ticks and delivers them one pulse at a time, waiting
// for an acknowledge between deliveries. Reprogram and unmask strobes
// empty the backlog and make the handshake ready.
// Assumes: synchronous inputs; strobes may coincide in any combination.
module reinj_tracker #(
    parameter int CNT_W      = 4,
    parameter int PULSE_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ack_i,
    input  logic reload_i,
    input  logic unmask_i,
    input  logic inject_en_i,
    output logic irq_o,
    output logic pending_o
);
    logic clear;
    logic acked;
    logic shaper_idle;
    logic fire;

    assign clear = reload_i || unmask_i;
    assign fire  = pending_o && acked && inject_en_i && shaper_idle && !clear;

    reinj_backlog #(.CNT_W(CNT_W)) u_backlog (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .dec_i     (ack_i),
        .clear_i   (clear),
        .nonzero_o (pending_o)
    );

    reinj_handshake u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .fire_i  (fire),
        .ack_i   (ack_i),
        .acked_o (acked)
    );

    reinj_pulse #(.PULSE_HIGH(PULSE_HIGH)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .idle_o (shaper_idle),
        .irq_o  (irq_o)
    );

    p_rise_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(acked) && $past(pending_o)));
    p_rise_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(inject_en_i));
    p_no_rise_on_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !$past(clear));

endmodule

// File: tb/sim_reinj_tracker.sv
module sim_reinj_tracker;
    localparam int CNT_W      = 4;
    localparam int PULSE_HIGH = 2;
    localparam int MAXV       = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, ack = 1'b0, reload = 1'b0, unmask = 1'b0, en = 1'b0;
    logic irq, pend;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state
    int  m_cnt;
    bit  m_acked;
    int  m_ph;      // 0 idle, 1 high, 2 gap
    int  m_hi;

    always #5 clk = ~clk;

    reinj_tracker #(.CNT_W(CNT_W), .PULSE_HIGH(PULSE_HIGH)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ack_i(ack),
        .reload_i(reload), .unmask_i(unmask), .inject_en_i(en),
        .irq_o(irq), .pending_o(pend)
    );

    function automatic int f_next_cnt(int c, bit t, bit a, bit clr);
        bit d;
        if (clr) return 0;
        d = a && (c != 0);
        if (t && !d) return (c == MAXV) ? MAXV : c + 1;
        if (d && !t) return c - 1;
        return c;
    endfunction

    function automatic bit f_fire(int c, bit ak, bit e, int ph, bit clr);
        return (c != 0) && ak && e && (ph == 0) && !clr;
    endfunction

    task automatic check(input string req, input bit act, input bit exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit clr, fire;
        if (!rst_n) begin
            m_cnt = 0; m_acked = 1; m_ph = 0; m_hi = 0;
            return;
        end
        clr  = reload || unmask;
        fire = f_fire(m_cnt, m_acked, en, m_ph, clr);
        if (clr)       m_acked = 1;
        else if (fire) m_acked = 0;
        else if (ack)  m_acked = 1;
        m_cnt = f_next_cnt(m_cnt, tick, ack, clr);
        case (m_ph)
            0: if (fire) begin m_ph = 1; m_hi = PULSE_HIGH - 1; end
            1: if (m_hi == 0) m_ph = 2; else m_hi--;
            default: m_ph = 0;
        endcase
    endtask

    // One cycle: drive at negedge, update model after posedge, compare at negedge
    task automatic step(input bit t, input bit a, input bit r, input bit u, input bit e, input string req);
        tick = t; ack = a; reload = r; unmask = u; en = e;
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(req, irq, (m_ph == 1), "irq_o");
        check(req, pend, (m_cnt != 0), "pending_o");
    endtask

    task automatic idle(input int n, input bit e, input string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, e, req);
    endtask

    initial begin
        int pulses;
        int high_len;
        bit seen_rise;
        void'($urandom(32'd20240611));
        m_cnt = 0; m_acked = 1; m_ph = 0; m_hi = 0;
        @(negedge clk);
        idle(3, 0, "R1");
        rst_n = 1'b1;
        idle(2, 1, "R1");
        check("R1", irq, 1'b0, "irq_o after reset");
        check("R1", pend, 1'b0, "pending_o after reset");

        // R2/R3: one tick delivered without prior ack
        step(1, 0, 0, 0, 1, "R2");
        check("R2", pend, 1'b1, "pending after tick");
        step(0, 0, 0, 0, 1, "R3");
        check("R3", irq, 1'b1, "irq rises next cycle");
        // R7: measure high width
        high_len = 1;
        for (int i = 0; i < 6; i++) begin
            step(0, 0, 0, 0, 1, "R7");
            if (irq) high_len++;
        end
        check("R7", (high_len == PULSE_HIGH), 1'b1, "high width equals PULSE_HIGH");
        // R3: second tick while unacked does not deliver
        step(1, 0, 0, 0, 1, "R3");
        seen_rise = 0;
        for (int i = 0; i < 6; i++) begin
            step(0, 0, 0, 0, 1, "R3");
            if (irq) seen_rise = 1;
        end
        check("R3", seen_rise, 1'b0, "no delivery without ack");
        // R4: ack releases next delivery
        step(0, 1, 0, 0, 1, "R4");
        idle(6, 1, "R4");
        step(0, 1, 0, 0, 1, "R4");
        idle(2, 1, "R4");
        check("R4", pend, 1'b0, "backlog drained");
        // R4: ack at empty backlog
        step(0, 1, 0, 0, 1, "R4");
        check("R4", pend, 1'b0, "ack at zero stays zero");

        // R9: tie at zero gives one, tie at nonzero unchanged
        step(1, 1, 0, 0, 0, "R9");
        check("R9", pend, 1'b1, "tick+ack at zero");
        step(1, 1, 0, 0, 0, "R9");
        step(0, 1, 0, 0, 0, "R9");
        check("R9", pend, 1'b0, "single ack drains after tie");

        // R10: held-off delivery, then resume
        step(1, 0, 0, 0, 0, "R10");
        idle(5, 0, "R10");
        check("R10", irq, 1'b0, "no irq while disabled");
        check("R10", pend, 1'b1, "tick counted while disabled");
        idle(2, 1, "R10");
        check("R10", irq, 1'b1, "delivery resumes");
        idle(4, 1, "R10");

        // R5: reload clears and wins over tick in same cycle
        step(1, 0, 0, 0, 0, "R5");
        step(1, 1, 1, 0, 1, "R5");
        check("R5", pend, 1'b0, "reload empties backlog");
        step(1, 0, 0, 0, 1, "R5");
        idle(1, 1, "R5");
        check("R5", irq, 1'b1, "ready after reload");
        idle(4, 1, "R5");
        // R6: unmask clears
        step(1, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 1, 0, "R6");
        check("R6", pend, 1'b0, "unmask empties backlog");
        idle(2, 0, "R6");

        // R8: saturate and count deliveries to drain
        for (int i = 0; i < MAXV + 5; i++) step(1, 0, 0, 0, 0, "R8");
        pulses = 0;
        for (int i = 0; i < 400 && pend; i++) begin
            step(0, 0, 0, 0, 1, "R8");
            if (irq) begin
                pulses++;
                while (irq) step(0, 0, 0, 0, 1, "R8");
                step(0, 1, 0, 0, 1, "R8");
            end
        end
        check("R8", (pulses == MAXV), 1'b1, "deliveries to drain saturated backlog");
        step(0, 0, 1, 0, 1, "R8");

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 97) == 0,
                 ($urandom % 113) == 0, ($urandom % 10) != 0, "R2/R3/R4 random");
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule